// File: doc/BRIEF.md
# SDRAM Clock Phase Shifter

This block derives five SDRAM clock outputs from a reference clock that runs at twice the core rate. One reference tick is therefore half a core clock. An internal counter builds an unshifted clock with a period of `2*HALF_T` ticks, high for the first half. A tap select on a six-stage delay line then delays that clock by 0 to 6 ticks, so the phase can be set from 0 to 3 core clocks in half-clock steps to tune setup and hold margins at the memory. A one-tick pulse, `ref_sync_o`, marks each rising edge of the unshifted clock, so that the shift can be observed from outside.

A 32-bit configuration word holds five fields:
- the shift code;
- five active-low output masks;
- a 2-bit drive/slew code, passed straight to the pads;
- a read-phase bit;
- reserved bits, which are always zero.

A newly written shift code only becomes pending. It is copied into the active shift when `start_i` goes from 0 to 1, and the copy happens during a cycle in which both the old and the new shifted clocks are low. The block also produces a read-data capture strobe, placed after each rising edge of the shifted clock.

Top module: `sdclk_phase_shifter`

## Requirements
- R1: With shift code n (n from 0 to 6, in bits [3:1] of the configuration word), every rising edge of `sdclk_o` comes exactly n ticks after the `ref_sync_o` pulse of the same period.
- R2: A write whose shift code is 3'b111 leaves the stored shift field and the active shift unchanged. All other fields of that write are stored normally.
- R3: A newly written shift code does not change the clock outputs until `start_i` has made a 0-to-1 transition.
- R4: Configuration bit 7+i is the mask of `sdclk_o[i]`, for i from 0 to 4. Value 1 holds the output low and value 0 lets the shifted clock through.
- R5: `cap_o` pulses for one tick, 2 ticks after each rising edge of the shifted clock when bit 0 is 0, and 4 ticks after it when bit 0 is 1.
- R6: `drive_o` always equals configuration bits [5:4], where 00 is the weakest drive and 11 the strongest.
- R7: The configuration word resets to 0x00000801. Bits 6 and 31:12 read back as zero whatever is written to them.
- R8: The active shift changes only in a tick in which the shifted clock is low. Every high pulse on an enabled output lasts exactly `HALF_T` ticks.
- R9: A change to a mask takes effect only while that lane's shifted clock is low, so masking or unmasking never shortens a high pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the core rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Stored configuration word |
| start_i | input | 1 | Start control; a rising edge arms loading of the pending shift |
| sdclk_o | output | 5 | Shifted, maskable clock outputs |
| ref_sync_o | output | 1 | One-tick pulse marking each unshifted rising edge |
| cap_o | output | 1 | Read-data capture strobe |
| drive_o | output | 2 | Drive/slew code for the pads |

## Verification
The assertions assume that `HALF_T` exceeds the largest tap (6). Under that condition, the old and new shifted clocks always share a low tick, so every armed load eventually completes. They also assume that `start_i` changes only between edges and that writes arrive as single-tick strobes. The stimulus drives every input at the falling edge, and it holds `start_i` high for two ticks. After each start pulse it waits more than one full clock period before measuring an edge offset, so a measurement never straddles a shift load.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int CFG_W     = 32;
  localparam int RD_BIT    = 0;
  localparam int SHIFT_LSB = 1;
  localparam int SHIFT_W   = 3;
  localparam int DRV_LSB   = 4;
  localparam int DRV_W     = 2;
  localparam int MASK_LSB  = 7;
  localparam int N_OUT     = 5;
  localparam int MAX_TAP   = 6;
  localparam int TPC       = 2;  // reference ticks per core clock
  localparam logic [SHIFT_W-1:0] SHIFT_RSVD = 3'b111;
  localparam logic [CFG_W-1:0]   CFG_RST    = 32'h0000_0801;
  localparam int USED_TOP  = MASK_LSB + N_OUT;
  localparam logic [CFG_W-1:0] CFG_WMASK =
    ((CFG_W'(1) << USED_TOP) - CFG_W'(1)) & ~(CFG_W'(1) << (DRV_LSB + DRV_W));

  typedef struct packed {
    logic [N_OUT-1:0]   mask;
    logic [DRV_W-1:0]   drv;
    logic [SHIFT_W-1:0] shift;
    logic               rd;
  } cfg_t;
endpackage

// File: rtl/sdclk_cfg_reg.sv
module sdclk_cfg_reg
  import sdclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output cfg_t             cfg
);
  logic [CFG_W-1:0] q;
  logic [CFG_W-1:0] nxt;

  // Reserved bits are masked off; the reserved shift code keeps the old field.
  always_comb begin
    nxt = wdata & CFG_WMASK;
    if (wdata[SHIFT_LSB +: SHIFT_W] == SHIFT_RSVD)
      nxt[SHIFT_LSB +: SHIFT_W] = q[SHIFT_LSB +: SHIFT_W];
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= CFG_RST;
    else if (we) q <= nxt;
  end

  assign rdata     = q;
  assign cfg.rd    = q[RD_BIT];
  assign cfg.shift = q[SHIFT_LSB +: SHIFT_W];
  assign cfg.drv   = q[DRV_LSB +: DRV_W];
  assign cfg.mask  = q[MASK_LSB +: N_OUT];
endmodule

// File: rtl/sdclk_phase_core.sv
module sdclk_phase_core
  import sdclk_pkg::*;
#(
  parameter int HALF_T = 8,
  localparam int PER   = 2 * HALF_T,
  localparam int CNT_W = $clog2(PER)
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [SHIFT_W-1:0] pend_tap,
  output logic               sel_o,
  output logic               clk_int_o,
  output logic               sync_o,
  output logic [SHIFT_W-1:0] act_tap_o,
  output logic               armed_o
);
  logic [CNT_W-1:0]   cnt;
  logic               base;
  logic [MAX_TAP-1:0] dl;
  logic               start_q;
  logic [SHIFT_W-1:0] tgt;
  logic               old_sel, new_sel;

  always_ff @(posedge clk) begin
    if (rst)                            cnt <= '0;
    else if (cnt == CNT_W'(PER - 1))    cnt <= '0;
    else                                cnt <= cnt + CNT_W'(1);
  end

  assign base = (cnt < CNT_W'(HALF_T));

  for (genvar g = 0; g < MAX_TAP; g++) begin : g_dl
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) dl[0] <= 1'b0;
        else     dl[0] <= base;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) dl[g] <= 1'b0;
        else     dl[g] <= dl[g-1];
      end
    end
  end

  function automatic logic pick(input logic [SHIFT_W-1:0] t,
                                input logic b,
                                input logic [MAX_TAP-1:0] d);
    logic r;
    r = b;
    for (int k = 1; k <= MAX_TAP; k++)
      if (t == SHIFT_W'(k)) r = d[k-1];
    return r;
  endfunction

  assign old_sel = pick(act_tap_o, base, dl);
  assign new_sel = pick(tgt, base, dl);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q   <= 1'b0;
      armed_o   <= 1'b0;
      tgt       <= '0;
      act_tap_o <= '0;
      clk_int_o <= 1'b0;
      sync_o    <= 1'b0;
    end else begin
      start_q <= start_i;
      if (start_i && !start_q) begin
        tgt     <= pend_tap;
        armed_o <= 1'b1;
      end else if (armed_o && !old_sel && !new_sel) begin
        act_tap_o <= tgt;
        armed_o   <= 1'b0;
      end
      clk_int_o <= old_sel;
      sync_o    <= (cnt == '0);
    end
  end

  assign sel_o = old_sel;
endmodule

// File: rtl/sdclk_lane.sv
module sdclk_lane #(
  parameter bit RST_EN = 1'b1
)(
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic mask_i,
  output logic clk_o
);
  logic en;

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= RST_EN;
      clk_o <= 1'b0;
    end else begin
      if (!sel_i) en <= !mask_i;
      clk_o <= sel_i & en;
    end
  end
endmodule

// File: rtl/sdclk_capture.sv
module sdclk_capture
  import sdclk_pkg::*;
#(
  parameter int MAX_CORE = 2,
  localparam int STG     = TPC * MAX_CORE - 1,
  localparam int IDX_LO  = TPC - 2,
  localparam int IDX_HI  = TPC * MAX_CORE - 2
)(
  input  logic clk,
  input  logic rst,
  input  logic clk_int,
  input  logic rd_i,
  output logic cap_o
);
  logic           clk_d;
  logic           rise;
  logic [STG-1:0] p;

  assign rise = clk_int & ~clk_d;

  for (genvar g = 0; g < STG; g++) begin : g_pipe
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) p[0] <= 1'b0;
        else     p[0] <= rise;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) p[g] <= 1'b0;
        else     p[g] <= p[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_d <= 1'b0;
      cap_o <= 1'b0;
    end else begin
      clk_d <= clk_int;
      cap_o <= rd_i ? p[IDX_HI] : p[IDX_LO];
    end
  end
endmodule

// File: rtl/sdclk_phase_shifter.sv
module sdclk_phase_shifter
  import sdclk_pkg::*;
#(
  parameter int HALF_T = 8
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             start_i,
  output logic [N_OUT-1:0] sdclk_o,
  output logic             ref_sync_o,
  output logic             cap_o,
  output logic [DRV_W-1:0] drive_o
);
  cfg_t               cfg;
  logic               sel;
  logic               clk_int;
  logic [SHIFT_W-1:0] act_tap;
  logic               armed;

  sdclk_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg)
  );

  sdclk_phase_core #(.HALF_T(HALF_T)) u_core (
    .clk(clk), .rst(rst), .start_i(start_i), .pend_tap(cfg.shift),
    .sel_o(sel), .clk_int_o(clk_int), .sync_o(ref_sync_o),
    .act_tap_o(act_tap), .armed_o(armed)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_lane
    sdclk_lane #(.RST_EN(!CFG_RST[MASK_LSB + i])) u_lane (
      .clk(clk), .rst(rst), .sel_i(sel), .mask_i(cfg.mask[i]),
      .clk_o(sdclk_o[i])
    );
  end

  sdclk_capture u_cap (
    .clk(clk), .rst(rst), .clk_int(clk_int), .rd_i(cfg.rd), .cap_o(cap_o)
  );

  assign drive_o = cfg.drv;
endmodule

// File: rtl/sdclk_phase_chk.sv
module sdclk_phase_chk
  import sdclk_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [CFG_W-1:0]   cfg_rdata,
  input logic [N_OUT-1:0]   sdclk_o,
  input logic               cap_o,
  input logic [SHIFT_W-1:0] act_tap,
  input logic               armed,
  input logic               clk_int
);
  // R3
  shift_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (act_tap != $past(act_tap)) |-> $past(armed));

  // R2
  tap_range_chk: assert property (@(posedge clk) disable iff (rst)
    act_tap <= SHIFT_W'(MAX_TAP));

  // R8
  load_low_chk: assert property (@(posedge clk) disable iff (rst)
    (act_tap != $past(act_tap)) |-> !clk_int);

  // R7
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata & ~CFG_WMASK) == '0);

  // R5
  cap_single_chk: assert property (@(posedge clk) disable iff (rst)
    cap_o |=> !cap_o);

  for (genvar i = 0; i < N_OUT; i++) begin : g_lane_chk
    // R4
    lane_en_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sdclk_o[i]) |-> !$past(cfg_rdata[MASK_LSB + i], 2));
  end
endmodule

bind sdclk_phase_shifter sdclk_phase_chk u_chk (
  .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .sdclk_o(sdclk_o),
  .cap_o(cap_o), .act_tap(act_tap), .armed(armed), .clk_int(clk_int)
);

// File: tb/sim_sdclk_phase_shifter.sv
`timescale 1ns/1ps
module sim_sdclk_phase_shifter;
  localparam int HT = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        start_i = 1'b0;
  logic [4:0]  sdclk_o;
  logic        ref_sync_o;
  logic        cap_o;
  logic [1:0]  drive_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int hl[5];
  int runt = 0;

  always #2.5 clk = ~clk;

  sdclk_phase_shifter #(.HALF_T(HT)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .start_i(start_i), .sdclk_o(sdclk_o),
    .ref_sync_o(ref_sync_o), .cap_o(cap_o), .drive_o(drive_o)
  );

  // R8 R9: every completed high pulse must last HT ticks
  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 5; i++) hl[i] = 0;
    end else begin
      for (int i = 0; i < 5; i++) begin
        if (sdclk_o[i]) hl[i]++;
        else if (hl[i] > 0) begin
          if (hl[i] != HT) runt++;
          hl[i] = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int code, input bit rd, input int drv,
                                     input logic [4:0] mask);
    return (32'(mask) << 7) | (32'(drv) << 4) | (32'(code) << 1) | 32'(rd);
  endfunction

  task automatic wr(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    ticks(2); start_i = 1'b0;
  endtask

  task automatic measure(output int off);
    logic p, rise;
    off = -1;
    rise = 1'b0;
    p = sdclk_o[0];
    do begin
      @(negedge clk);
      rise = sdclk_o[0] && !p;
      p = sdclk_o[0];
    end while (!ref_sync_o);
    if (rise) off = 0;
    else for (int k = 1; k <= 2 * HT && off < 0; k++) begin
      @(negedge clk);
      if (sdclk_o[0] && !p) off = k;
      p = sdclk_o[0];
    end
  endtask

  task automatic t_reset();
    int hi0, hi4;
    chk(cfg_rdata == 32'h801, "R7 reset value", int'(cfg_rdata), 32'h801);
    chk(drive_o == 2'b00, "R6 reset drive", int'(drive_o), 0);
    hi0 = 0; hi4 = 0;
    for (int k = 0; k < 2 * HT; k++) begin
      @(negedge clk);
      hi0 += int'(sdclk_o[0]);
      hi4 += int'(sdclk_o[4]);
    end
    chk(hi4 == 0, "R4 masked lane 4 low", hi4, 0);
    chk(hi0 == HT, "R4 enabled lane 0 toggles", hi0, HT);
  endtask

  task automatic t_shift_all();
    int off;
    for (int c = 0; c <= 6; c++) begin
      wr(mk(c, 1'b1, 0, 5'b10000));
      pulse_start();
      ticks(3 * HT);
      measure(off);
      chk(off == c, "R1 edge offset", off, c);
    end
  endtask

  task automatic t_pending();
    int off;
    wr(mk(2, 1'b1, 0, 5'b10000));
    ticks(3 * HT);
    measure(off);
    chk(off == 6, "R3 pending not applied", off, 6);
    pulse_start();
    ticks(3 * HT);
    measure(off);
    chk(off == 2, "R3 applied after start", off, 2);
  endtask

  task automatic t_reserved_code();
    int off;
    wr(mk(7, 1'b1, 0, 5'b10000));
    chk(cfg_rdata[3:1] == 3'd2, "R2 shift field kept", int'(cfg_rdata[3:1]), 2);
    pulse_start();
    ticks(3 * HT);
    measure(off);
    chk(off == 2, "R2 active shift kept", off, 2);
  endtask

  task automatic t_cap(input bit rd, input int exp);
    logic p;
    int got;
    wr(mk(2, rd, 0, 5'b10000));
    ticks(3 * HT);
    p = sdclk_o[0];
    do begin
      @(negedge clk);
      if (sdclk_o[0] && !p) break;
      p = sdclk_o[0];
    end while (1);
    got = -1;
    for (int k = 1; k <= 8 && got < 0; k++) begin
      @(negedge clk);
      if (cap_o) got = k;
    end
    chk(got == exp, "R5 capture delay", got, exp);
  endtask

  task automatic t_mask();
    int hi1, hi0;
    // mask lane 1 at an arbitrary point in the period (R9 via pulse monitor)
    ticks(3);
    wr(mk(2, 1'b1, 0, 5'b10010));
    ticks(2 * HT);
    hi1 = 0; hi0 = 0;
    for (int k = 0; k < 2 * HT; k++) begin
      @(negedge clk);
      hi1 += int'(sdclk_o[1]);
      hi0 += int'(sdclk_o[0]);
    end
    chk(hi1 == 0, "R4 masked lane 1 low", hi1, 0);
    chk(hi0 == HT, "R4 lane 0 still toggles", hi0, HT);
    ticks(5);
    wr(mk(2, 1'b1, 0, 5'b00000));
    ticks(2 * HT);
    hi1 = 0;
    for (int k = 0; k < 2 * HT; k++) begin
      @(negedge clk);
      hi1 += int'(sdclk_o[1]);
    end
    chk(hi1 == HT, "R4 unmasked lane 1 toggles", hi1, HT);
  endtask

  task automatic t_drive();
    wr(mk(2, 1'b1, 3, 5'b00000));
    chk(drive_o == 2'b11, "R6 drive strongest", int'(drive_o), 3);
    wr(mk(2, 1'b1, 1, 5'b00000));
    chk(drive_o == 2'b01, "R6 drive code 01", int'(drive_o), 1);
  endtask

  task automatic t_reserved_bits();
    logic [31:0] exp;
    int hi;
    exp = (32'hFFF & ~32'h40 & ~32'hE) | 32'h4;
    wr(32'hFFFF_FFFF);
    chk(cfg_rdata == exp, "R7 reserved bits zero", int'(cfg_rdata), int'(exp));
    ticks(2 * HT);
    hi = 0;
    for (int k = 0; k < 2 * HT; k++) begin
      @(negedge clk);
      hi += int'(sdclk_o != 5'b0);
    end
    chk(hi == 0, "R4 all lanes masked", hi, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    ticks(4);
    rst = 1'b0;
    t_reset();
    t_shift_all();
    t_pending();
    t_reserved_code();
    t_cap(1'b0, 2);
    t_cap(1'b1, 4);
    t_mask();
    t_drive();
    t_reserved_bits();
    ticks(2 * HT);
    chk(runt == 0, "R8 R9 no shortened high pulse", runt, 0);
    finish_run();
  end
endmodule